// File: doc/BRIEF.md
# Multicycle RISC Control Sequencer

This block is a small 32-bit load/store processor core built as a multicycle machine. One datapath and a five-step state graph (fetch, decode, execute, memory, write-back) carry each instruction. Every instruction class visits only the steps it needs, so a branch finishes in three cycles and a load needs five. The core has one word-addressed memory port that serves both instruction fetch and data access, and a 32-entry register file of its own.

Six instruction classes are handled: register-register add and subtract, OR with an immediate, load word, store word and branch-if-equal. Any other encoding is skipped as a no-op. A halt input stops the core at the next fetch boundary, and the program counter is brought out so that a debugger can see where the core stopped.

Top module: `mcs_core`

## Requirements
- R1: While reset is asserted and in the cycle after its release, pc_view is 0, mem_we is 0, and (when halt_req is low) mem_re is 1 with mem_addr 0.
- R2: Each fetch reads the word at pc_view/4 and raises pc_view by 4 at the same clock edge.
- R3: Opcode 0 with funct 0x21 writes rs+rt to rd, and funct 0x23 writes rs-rt to rd, both modulo 2^32. Each takes 4 cycles from fetch to the next fetch.
- R4: Opcode 0x0D writes rs OR the zero-extended bits 15:0 to rt, in 4 cycles.
- R5: Opcode 0x23 loads rt from word (rs + sign-extended bits 15:0)/4, in 5 cycles.
- R6: Opcode 0x2B writes rt to word (rs + sign-extended bits 15:0)/4 with one write pulse and no read in that cycle, in 4 cycles.
- R7: Opcode 0x04 sets the PC to PC+4+(sign-extended bits 15:0 shifted left by 2) when rs equals rt, and otherwise to PC+4, in 3 cycles.
- R8: Register 0 reads as zero, and a write to register 0 is ignored.
- R9: An unknown opcode, or opcode 0 with a funct other than 0x21 or 0x23, changes no state apart from the PC step and returns to fetch after 2 cycles.
- R10: While halt_req is high at a fetch boundary, halted is 1, no memory access takes place and pc_view holds. Execution resumes in the first cycle after halt_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req | input | 1 | Stop before the next fetch while high |
| mem_rdata | input | XLEN | Read data for mem_addr, combinational |
| mem_addr | output | AW | Word address for fetch or data access |
| mem_re | output | 1 | Read strobe (fetch or load) |
| mem_we | output | 1 | Write strobe (store) |
| mem_wdata | output | XLEN | Store data |
| pc_view | output | XLEN | Current program counter (byte address) |
| halted | output | 1 | Core is parked at a fetch boundary |

## Verification
The bench goes after the wrap cases of add and subtract, and after an OR-immediate with bit 15 set. A design that sign-extended that immediate would set the upper half of the result. It runs a taken branch over a store and a not-taken branch in front of one. A wrong offset base or a missing shift would leave the skipped word written or the wrong word stored. It times each class from PC step to PC step, which catches a state graph that visits a step a class does not need. It also stores register 0 after a write to it, and holds the core in halt from reset, so a leaking write or a fetch during halt shows up at the ports.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB} step_e;
   typedef enum logic [2:0] {K_ADD, K_SUB, K_ORI, K_LW, K_SW, K_BEQ, K_NONE} kind_e;
   typedef enum logic [1:0] {F_ADD, F_SUB, F_OR} alu_e;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] FN_ADD   = 6'h21;
   localparam logic [5:0] FN_SUB   = 6'h23;

   function automatic kind_e classify(input logic [5:0] op, input logic [5:0] fn);
      kind_e k;
      case (op)
         OP_RTYPE: k = (fn == FN_ADD) ? K_ADD : ((fn == FN_SUB) ? K_SUB : K_NONE);
         OP_ORI:   k = K_ORI;
         OP_LW:    k = K_LW;
         OP_SW:    k = K_SW;
         OP_BEQ:   k = K_BEQ;
         default:  k = K_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/mcs_regfile.sv
module mcs_regfile #(
   parameter int XLEN     = 32,
   parameter int NREG     = 32,
   parameter bit RF_RESET = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] waddr,
   input  logic [XLEN-1:0]         wdata,
   input  logic [$clog2(NREG)-1:0] ra1,
   input  logic [$clog2(NREG)-1:0] ra2,
   output logic [XLEN-1:0]         rd1,
   output logic [XLEN-1:0]         rd2
);
   localparam int IW = $clog2(NREG);

   logic [XLEN-1:0] regs [NREG];
   logic            wr_ok;

   // register 0 is never written
   assign wr_ok = we && (waddr != IW'(0));

   generate
      if (RF_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) regs[i] <= '0;
            end else if (wr_ok) begin
               regs[waddr] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_ok) regs[waddr] <= wdata;
         end
      end
   endgenerate

   assign rd1 = (ra1 == IW'(0)) ? '0 : regs[ra1];
   assign rd2 = (ra2 == IW'(0)) ? '0 : regs[ra2];

endmodule

// File: rtl/mcs_alu.sv
module mcs_alu
   import mcs_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  alu_e            fn,
   input  logic [XLEN-1:0] x,
   input  logic [XLEN-1:0] y,
   output logic [XLEN-1:0] r
);
   always_comb begin
      case (fn)
         F_SUB:   r = x - y;
         F_OR:    r = x | y;
         default: r = x + y;
      endcase
   end
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
   import mcs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  halt_req,
   input  kind_e kind,
   output step_e step,
   output logic  halted
);
   step_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step <= S_FETCH;
      else        step <= nxt;
   end

   always_comb begin
      nxt = S_FETCH;
      case (step)
         S_FETCH:  nxt = halt_req ? S_FETCH : S_DECODE;
         S_DECODE: nxt = (kind == K_NONE) ? S_FETCH : S_EXEC;
         S_EXEC: begin
            case (kind)
               K_BEQ:       nxt = S_FETCH;
               K_LW, K_SW:  nxt = S_MEM;
               default:     nxt = S_WB;
            endcase
         end
         S_MEM:    nxt = (kind == K_LW) ? S_WB : S_FETCH;
         S_WB:     nxt = S_FETCH;
         default:  nxt = S_FETCH;
      endcase
   end

   assign halted = (step == S_FETCH) && halt_req;

endmodule

// File: rtl/mcs_core.sv
module mcs_core
   import mcs_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              AW       = 10,
   parameter int              NREG     = 32,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter bit              RF_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt_req,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_re,
   output logic            mem_we,
   output logic [XLEN-1:0] mem_wdata,
   output logic [XLEN-1:0] pc_view,
   output logic            halted
);
   localparam int IW   = $clog2(NREG);
   localparam int IMMW = 16;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mcs_core: instruction layout needs XLEN of 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("mcs_core: register fields are 5 bits, NREG must be 32");
   end
   if (AW < 2 || AW > XLEN - 2) begin : g_bad_aw
      $error("mcs_core: AW out of range");
   end

   logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, s_q, m_q;
   logic [IMMW-1:0] imm_q;

   step_e           step;
   kind_e           kind;
   alu_e            alu_fn;
   logic [XLEN-1:0] alu_x, alu_y, alu_r;
   logic [XLEN-1:0] imm_s, imm_z;
   logic [XLEN-1:0] rd1, rd2, wb_data;
   logic [IW-1:0]   wb_addr;
   logic            wb_en, fetch_go;

   assign kind  = classify(ir_q[31:26], ir_q[5:0]);
   assign imm_s = {{(XLEN-IMMW){imm_q[IMMW-1]}}, imm_q};
   assign imm_z = {{(XLEN-IMMW){1'b0}}, imm_q};

   mcs_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .halt_req (halt_req),
      .kind     (kind),
      .step     (step),
      .halted   (halted)
   );

   mcs_regfile #(.XLEN(XLEN), .NREG(NREG), .RF_RESET(RF_RESET)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wb_en),
      .waddr (wb_addr),
      .wdata (wb_data),
      .ra1   (ir_q[25:21]),
      .ra2   (ir_q[20:16]),
      .rd1   (rd1),
      .rd2   (rd2)
   );

   // operand selection per class for the execute step
   always_comb begin
      alu_fn = F_ADD;
      alu_x  = a_q;
      alu_y  = b_q;
      case (kind)
         K_SUB:      alu_fn = F_SUB;
         K_ORI: begin
            alu_fn = F_OR;
            alu_y  = imm_z;
         end
         K_LW, K_SW: alu_y = imm_s;
         K_BEQ: begin
            alu_x = npc_q;
            alu_y = imm_s << 2;
         end
         default: ;
      endcase
   end

   mcs_alu #(.XLEN(XLEN)) u_alu (
      .fn (alu_fn),
      .x  (alu_x),
      .y  (alu_y),
      .r  (alu_r)
   );

   assign fetch_go = (step == S_FETCH) && !halt_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         npc_q <= RESET_PC;
         ir_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         imm_q <= '0;
         s_q   <= '0;
         m_q   <= '0;
      end else begin
         case (step)
            S_FETCH: begin
               if (fetch_go) begin
                  ir_q  <= mem_rdata;
                  pc_q  <= pc_q + XLEN'(4);
                  npc_q <= pc_q + XLEN'(4);
               end
            end
            S_DECODE: begin
               a_q   <= rd1;
               b_q   <= rd2;
               imm_q <= ir_q[IMMW-1:0];
            end
            S_EXEC: begin
               s_q <= alu_r;
               if (kind == K_BEQ) pc_q <= (a_q == b_q) ? alu_r : npc_q;
            end
            S_MEM: begin
               if (kind == K_LW) m_q <= mem_rdata;
            end
            default: ;
         endcase
      end
   end

   assign wb_en    = (step == S_WB);
   assign wb_addr  = (kind == K_ADD || kind == K_SUB) ? ir_q[15:11] : ir_q[20:16];
   assign wb_data  = (kind == K_LW) ? m_q : s_q;

   assign mem_addr  = (step == S_FETCH) ? pc_q[AW+1:2] : s_q[AW+1:2];
   assign mem_re    = fetch_go || ((step == S_MEM) && (kind == K_LW));
   assign mem_we    = (step == S_MEM) && (kind == K_SW);
   assign mem_wdata = b_q;
   assign pc_view   = pc_q;

endmodule

// File: rtl/mcs_core_chk.sv
module mcs_core_chk
   import mcs_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            halt_req,
   input logic            mem_re,
   input logic            mem_we,
   input logic            halted,
   input logic [XLEN-1:0] pc_view,
   input logic [XLEN-1:0] ir_q,
   input logic [XLEN-1:0] a_q,
   input step_e           step
);
   AST_STORE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_re);                                                   // R6
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_re && !mem_we));                                      // R10
   AST_HALT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc_view));                                          // R10
   AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step == S_FETCH && !halt_req) |=> (pc_view == $past(pc_view) + 32'd4)); // R2
   AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (step == S_DECODE && ir_q[25:21] == 5'd0) |=> (a_q == '0));            // R8
   AST_BRANCH_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (step == S_EXEC && ir_q[31:26] == OP_BEQ) |=> (step == S_FETCH));      // R7
   AST_UNKNOWN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (step == S_DECODE && classify(ir_q[31:26], ir_q[5:0]) == K_NONE)
      |=> (step == S_FETCH));                                                // R9
endmodule

bind mcs_core mcs_core_chk #(.XLEN(XLEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .halt_req (halt_req),
   .mem_re   (mem_re),
   .mem_we   (mem_we),
   .halted   (halted),
   .pc_view  (pc_view),
   .ir_q     (ir_q),
   .a_q      (a_q),
   .step     (step)
);

// File: tb/mcs_core_test.sv
module mcs_core_test;
   localparam int XLEN = 32;
   localparam int AW   = 8;
   localparam int NVEC = 7;

   // kind: 0 add, 1 sub, 2 or-immediate (y[15:0] is the immediate)
   localparam logic [97:0] VEC [NVEC] = '{
      {2'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
      {2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
      {2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
      {2'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
      {2'd1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF},
      {2'd2, 32'hF0F0_0000, 32'h0000_8001, 32'hF0F0_8001},
      {2'd2, 32'h0000_000F, 32'h0000_00F0, 32'h0000_00FF}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            halt_req = 1'b0;
   logic [XLEN-1:0] mem_rdata, mem_wdata, pc_view;
   logic [AW-1:0]   mem_addr;
   logic            mem_re, mem_we, halted;
   logic [XLEN-1:0] mem [2**AW];
   int              nchk = 0;
   int              nbad = 0;

   always #2 clk = ~clk;

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   mcs_core #(.XLEN(XLEN), .AW(AW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt_req  (halt_req),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_re    (mem_re),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .pc_view   (pc_view),
      .halted    (halted)
   );

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction
   function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 2**AW; i++) mem[i] = '0;
   endtask

   task automatic start(logic hold);
      rst_n    = 1'b0;
      halt_req = hold;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 4);
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      // table walk: R3 add/sub, R4 or-immediate, through R5 loads and R6 stores
      for (int v = 0; v < NVEC; v++) begin
         clear_mem();
         mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
         mem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
         case (VEC[v][97:96])
            2'd0:    mem[2] = enc_r(6'h21, 5'd1, 5'd2, 5'd3);
            2'd1:    mem[2] = enc_r(6'h23, 5'd1, 5'd2, 5'd3);
            default: mem[2] = enc_i(6'h0D, 5'd1, 5'd3, VEC[v][47:32]);
         endcase
         mem[3]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
         mem[4]  = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
         mem[64] = VEC[v][95:64];
         mem[65] = VEC[v][63:32];
         mem[66] = 32'hCAFE_F00D;
         start(1'b0);
         step(30);
         check(VEC[v][97:96] == 2'd2 ? "R4 or-immediate" : "R3 add/sub", mem[66], VEC[v][31:0]);
      end

      // directed program: timing per class, branches, register 0
      clear_mem();
      mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);   // r1 = 5
      mem[1]  = enc_i(6'h0D, 5'd0, 5'd2, 16'h0005);   // r2 = 5
      mem[2]  = enc_i(6'h04, 5'd1, 5'd2, 16'h0001);   // taken, skips word 3
      mem[3]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h010C);
      mem[4]  = enc_r(6'h21, 5'd1, 5'd2, 5'd0);       // write to r0
      mem[5]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0110);   // store r0
      mem[6]  = 32'hFC00_0000;                        // opcode 0x3F
      mem[7]  = enc_r(6'h00, 5'd1, 5'd2, 5'd3);       // funct 0
      mem[8]  = enc_i(6'h04, 5'd1, 5'd0, 16'h0005);   // not taken
      mem[9]  = enc_i(6'h2B, 5'd0, 5'd1, 16'h0114);
      mem[10] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
      mem[64] = 32'd5;
      mem[67] = 32'h0000_1111;
      mem[68] = 32'h0000_DEAD;
      mem[69] = 32'h0;
      start(1'b0);
      check("R1 pc after reset", pc_view, 32'd0);
      check("R1 read strobe", {31'd0, mem_re}, 32'd1);
      check("R1 address", {24'd0, mem_addr}, 32'd0);
      check("R1 no write", {31'd0, mem_we}, 32'd0);
      step(1);
      check("R2 pc step", pc_view, 32'd4);
      step(4);
      check("R5 load still busy", pc_view, 32'd4);
      step(1);
      check("R5 load in 5", pc_view, 32'd8);
      step(3);
      check("R4 ori busy", pc_view, 32'd8);
      step(1);
      check("R4 ori in 4", pc_view, 32'd12);
      step(2);
      check("R7 taken target", pc_view, 32'd16);
      step(1);
      check("R7 taken in 3", pc_view, 32'd20);
      step(3);
      check("R3 add busy", pc_view, 32'd20);
      step(1);
      check("R3 add in 4", pc_view, 32'd24);
      step(4);
      check("R6 store in 4", pc_view, 32'd28);
      step(1);
      check("R9 unknown busy", pc_view, 32'd28);
      step(1);
      check("R9 unknown in 2", pc_view, 32'd32);
      step(2);
      check("R9 bad funct in 2", pc_view, 32'd36);
      step(2);
      check("R7 not taken", pc_view, 32'd36);
      step(1);
      check("R7 fall through fetch", pc_view, 32'd40);
      step(12);
      check("R7 skipped store", mem[67], 32'h0000_1111);
      check("R8 r0 stays zero", mem[68], 32'h0);
      check("R6 stored word", mem[69], 32'd5);

      // halt held from reset
      start(1'b1);
      check("R10 halted flag", {31'd0, halted}, 32'd1);
      check("R10 no access", {30'd0, mem_re, mem_we}, 32'd0);
      step(4);
      check("R10 pc held", pc_view, 32'd0);
      halt_req = 1'b0;
      step(1);
      check("R10 resume", pc_view, 32'd4);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule